// File: doc/BRIEF.md
# Ring Qualification and Power Controller

This block decides whether the telephone line is carrying a genuine ring burst and, from that decision, controls how much of a caller-identification receiver is powered. An attenuated ring waveform, already reduced to a single comparator bit, drives a saturating up/down integrator. The integrator steps once per slow tick, which a prescaler derives from the system clock; the nominal tick rate is 800 Hz. The integrator steps up while the bit is high and down while it is low. A ring counts as qualified whenever the integrator holds at or above a fixed level, and an active-low ring indicator reports that state.

The integrator only runs while the line-activity input (the output of an external RC and Schmitt stage) is active. That same input also raises a wake request for the oscillator and bias, which gives a partial power-up. A qualified ring moves the receiver to full power. An automatic sleep timer then returns it to standby after a set number of ticks, unless a qualified ring or the carrier-valid flag from the FSK path keeps restarting the timer. The default is 2400 ticks, or 3 s. Independently of all this, an active-low forced power-up input holds the receiver fully powered.

Top module: `ring_power_ctrl`

## Requirements
- R1: The comparator, line-activity and forced power-up inputs each pass through a two-flop synchronizer. A change on the forced power-up input therefore reaches the full-power output at the third rising clock edge after it is applied, and not before.
- R2: The integrator changes only on a prescaler tick, and a tick occurs once every TICK_DIV clock cycles.
- R3: While line_act_n is low, the integrator rises by one per tick when the comparator bit is 1 and falls by one per tick when it is 0. While line_act_n is high, the integrator is held at zero, and comparator activity has no effect on ring_n.
- R4: The integrator saturates at CNT_MAX and at zero. Neither bound wraps, and a count held at a bound leaves it only by single steps.
- R5: ring_n is 0 while the integrator is at or above QUAL_LEVEL and 1 while it is below that level.
- R6: While force_on_n is low, full_pwr and wake_req are both 1, whatever the ring state. Releasing it with no other source active returns both to 0.
- R7: While line_act_n is low and no ring is qualified, wake_req is 1 and full_pwr is 0 (partial power-up).
- R8: A qualified ring sets the awake state, which drives full_pwr and wake_req to 1.
- R9: Once awake, full_pwr falls back to 0 after SLEEP_TICKS consecutive ticks with no qualified ring and no carrier_ok. wake_req also falls back to 0 if neither line activity nor forced power is present.
- R10: A qualified ring or a high carrier_ok clears the sleep timer, so the full countdown starts again after both have gone away.
- R11: After reset, ring_n is 1, and full_pwr and wake_req are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ring_cmp | input | 1 | Asynchronous comparator bit, attenuated ring above threshold |
| line_act_n | input | 1 | Asynchronous active-low line-activity level from the Schmitt stage |
| force_on_n | input | 1 | Asynchronous active-low forced power-up |
| carrier_ok | input | 1 | Synchronous carrier-valid flag from the FSK path |
| ring_n | output | 1 | Active-low qualified-ring indicator |
| full_pwr | output | 1 | Full-power enable for the receiver |
| wake_req | output | 1 | Oscillator and bias wake request |

## Verification
Two events can land in the same clock cycle: a sleep-timer tick that would end the awake state, and a qualified ring or carrier_ok that must clear the timer. The clear has to take priority. The bench provokes the collision by pulsing carrier_ok part of the way through a countdown. It then judges the result by the full-power output: that output must still be high at a point where an unrestarted timer would already have expired, and must drop only after a fresh countdown. A second overlap occurs when the integrator sits at either bound on a tick. Here the bench looks at the timing of qualification and disqualification after long saturating holds, using windows sized in ticks.

// File: rtl/rpc_pkg.sv
package rpc_pkg;
  // Synchronized, active-high view of the asynchronous inputs
  typedef struct packed {
    logic cmp;      // comparator bit
    logic line_act; // integrator enable / partial wake
    logic force_on; // forced full power
  } rpc_in_t;

  localparam int unsigned SYNC_STAGES = 2;
endpackage

// File: rtl/rpc_sync.sv
module rpc_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stage[0] <= '0;
          else     stage[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stage[s] <= '0;
          else     stage[s] <= stage[s-1];
        end
      end
    end
  endgenerate

  assign q = stage[STAGES-1];
endmodule

// File: rtl/rpc_prescale.sv
module rpc_prescale #(
  parameter int unsigned DIV = 4474
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int unsigned PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else begin
      tick <= (cnt == LAST);
      if (cnt == LAST) cnt <= '0;
      else             cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/rpc_integrator.sv
module rpc_integrator #(
  parameter int unsigned CNT_MAX    = 63,
  parameter int unsigned QUAL_LEVEL = 48,
  localparam int unsigned CW        = $clog2(CNT_MAX + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          enable,
  input  logic          up,
  output logic [CW-1:0] count,
  output logic          qual
);
  localparam logic [CW-1:0] CEIL = CW'(CNT_MAX);
  localparam logic [CW-1:0] QLVL = CW'(QUAL_LEVEL);

  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      count <= '0;
    end else if (tick) begin
      if (up) begin
        if (count != CEIL) count <= count + 1'b1;
      end else begin
        if (count != '0) count <= count - 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) qual <= 1'b0;
    else     qual <= (count >= QLVL);
  end
endmodule

// File: rtl/rpc_sleep.sv
module rpc_sleep #(
  parameter int unsigned SLEEP_TICKS = 2400,
  localparam int unsigned TW = (SLEEP_TICKS > 1) ? $clog2(SLEEP_TICKS) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          start,
  input  logic          hold,
  output logic          awake,
  output logic [TW-1:0] tmr
);
  localparam logic [TW-1:0] LAST = TW'(SLEEP_TICKS - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      awake <= 1'b0;
      tmr   <= '0;
    end else begin
      if (start) awake <= 1'b1;
      if (hold) begin
        tmr <= '0;
      end else if (awake && tick) begin
        if (tmr == LAST) begin
          awake <= 1'b0;
          tmr   <= '0;
        end else begin
          tmr <= tmr + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/ring_power_ctrl.sv
module ring_power_ctrl #(
  parameter int unsigned TICK_DIV    = 4474,
  parameter int unsigned CNT_MAX     = 63,
  parameter int unsigned QUAL_LEVEL  = 48,
  parameter int unsigned SLEEP_TICKS = 2400
) (
  input  logic clk,
  input  logic rst,
  input  logic ring_cmp,
  input  logic line_act_n,
  input  logic force_on_n,
  input  logic carrier_ok,
  output logic ring_n,
  output logic full_pwr,
  output logic wake_req
);
  import rpc_pkg::*;

  localparam int unsigned CW = $clog2(CNT_MAX + 1);
  localparam int unsigned TW = (SLEEP_TICKS > 1) ? $clog2(SLEEP_TICKS) : 1;

  rpc_in_t raw_in, syn_in;
  logic          tick;
  logic [CW-1:0] integ_count;
  logic          qual;
  logic          awake;
  logic [TW-1:0] sleep_tmr;

  assign raw_in = '{cmp: ring_cmp, line_act: ~line_act_n, force_on: ~force_on_n};

  rpc_sync #(.WIDTH($bits(rpc_in_t)), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk), .rst (rst), .d (raw_in), .q (syn_in)
  );

  rpc_prescale #(.DIV(TICK_DIV)) u_tick (
    .clk (clk), .rst (rst), .tick (tick)
  );

  rpc_integrator #(.CNT_MAX(CNT_MAX), .QUAL_LEVEL(QUAL_LEVEL)) u_integ (
    .clk (clk), .rst (rst), .tick (tick), .enable (syn_in.line_act),
    .up (syn_in.cmp), .count (integ_count), .qual (qual)
  );

  rpc_sleep #(.SLEEP_TICKS(SLEEP_TICKS)) u_sleep (
    .clk (clk), .rst (rst), .tick (tick), .start (qual),
    .hold (qual | carrier_ok), .awake (awake), .tmr (sleep_tmr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ring_n   <= 1'b1;
      full_pwr <= 1'b0;
      wake_req <= 1'b0;
    end else begin
      ring_n   <= ~qual;
      full_pwr <= syn_in.force_on | awake;
      wake_req <= syn_in.force_on | syn_in.line_act | awake;
    end
  end
endmodule

// File: rtl/rpc_checker.sv
module rpc_checker #(
  parameter int unsigned CNT_MAX     = 63,
  parameter int unsigned QUAL_LEVEL  = 48,
  parameter int unsigned SLEEP_TICKS = 2400,
  localparam int unsigned CW = $clog2(CNT_MAX + 1),
  localparam int unsigned TW = (SLEEP_TICKS > 1) ? $clog2(SLEEP_TICKS) : 1
) (
  input logic          clk,
  input logic          rst,
  input logic          tick,
  input logic          enable,
  input logic [CW-1:0] count,
  input logic          qual,
  input logic [TW-1:0] tmr,
  input logic          force_on,
  input logic          ring_n,
  input logic          full_pwr,
  input logic          wake_req
);
  p_cnt_ceiling_r4: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(CNT_MAX));

  p_hold_between_ticks_r2: assert property (@(posedge clk) disable iff (rst)
    (!tick && enable) |=> (count == $past(count)));

  p_single_step_r3: assert property (@(posedge clk) disable iff (rst)
    tick |=> (count == $past(count)) || (count == $past(count) + 1'b1) ||
             ($past(count) == count + 1'b1) || (count == '0));

  p_qual_level_r5: assert property (@(posedge clk) disable iff (rst)
    (count >= CW'(QUAL_LEVEL)) |=> qual);

  p_ring_powers_r8: assert property (@(posedge clk) disable iff (rst)
    !ring_n |=> full_pwr);

  p_force_powers_r6: assert property (@(posedge clk) disable iff (rst)
    force_on |=> (full_pwr && wake_req));

  p_full_implies_wake_r7: assert property (@(posedge clk) disable iff (rst)
    full_pwr |-> wake_req);

  p_timer_bound_r9: assert property (@(posedge clk) disable iff (rst)
    tmr <= TW'(SLEEP_TICKS - 1));

  p_timer_cleared_r10: assert property (@(posedge clk) disable iff (rst)
    qual |=> (tmr == '0));
endmodule

bind ring_power_ctrl rpc_checker #(
  .CNT_MAX(CNT_MAX), .QUAL_LEVEL(QUAL_LEVEL), .SLEEP_TICKS(SLEEP_TICKS)
) u_chk (
  .clk (clk), .rst (rst), .tick (tick), .enable (syn_in.line_act),
  .count (integ_count), .qual (qual), .tmr (sleep_tmr),
  .force_on (syn_in.force_on), .ring_n (ring_n), .full_pwr (full_pwr),
  .wake_req (wake_req)
);

// File: tb/ring_power_ctrl_test.sv
`timescale 1ns/1ps
module ring_power_ctrl_test;
  localparam int unsigned TD   = 8;
  localparam int unsigned CMAX = 15;
  localparam int unsigned QL   = 12;
  localparam int unsigned SL   = 20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ring_cmp = 1'b0, line_act_n = 1'b1, force_on_n = 1'b1, carrier_ok = 1'b0;
  logic ring_n, full_pwr, wake_req;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ring_power_ctrl #(.TICK_DIV(TD), .CNT_MAX(CMAX), .QUAL_LEVEL(QL), .SLEEP_TICKS(SL)) uut (
    .clk (clk), .rst (rst), .ring_cmp (ring_cmp), .line_act_n (line_act_n),
    .force_on_n (force_on_n), .carrier_ok (carrier_ok),
    .ring_n (ring_n), .full_pwr (full_pwr), .wake_req (wake_req)
  );

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wait_ring_off();
    for (int i = 0; i < 40 && ring_n !== 1'b1; i++) cyc(1);
  endtask

  initial begin
    cyc(5);
    rst = 1'b0;
    cyc(1);
    check("R11 ring_n", ring_n, 1'b1);
    check("R11 full_pwr", full_pwr, 1'b0);
    check("R11 wake_req", wake_req, 1'b0);

    // R1 latency, R6 forced power
    force_on_n = 1'b0;
    cyc(2);
    check("R1 full_pwr before third edge", full_pwr, 1'b0);
    cyc(1);
    check("R1 full_pwr at third edge", full_pwr, 1'b1);
    check("R6 wake_req forced", wake_req, 1'b1);
    force_on_n = 1'b1;
    cyc(5);
    check("R6 full_pwr released", full_pwr, 1'b0);
    check("R6 wake_req released", wake_req, 1'b0);

    // R3: integrator held while line inactive
    ring_cmp = 1'b1;
    cyc(25 * TD);
    check("R3 no ring while line idle", ring_n, 1'b1);
    check("R3 no wake while line idle", wake_req, 1'b0);

    // R7: partial wake
    ring_cmp = 1'b0;
    line_act_n = 1'b0;
    cyc(10);
    check("R7 wake_req partial", wake_req, 1'b1);
    check("R7 full_pwr partial", full_pwr, 1'b0);

    // R3/R5 count up to qualification
    ring_cmp = 1'b1;
    cyc((QL - 1) * TD);
    check("R5 not yet qualified", ring_n, 1'b1);
    check("R7 still partial", full_pwr, 1'b0);
    cyc(TD + 16);
    check("R5 qualified", ring_n, 1'b0);
    cyc(TD);
    check("R8 full_pwr on ring", full_pwr, 1'b1);
    check("R8 wake_req on ring", wake_req, 1'b1);

    // R4 ceiling: long high hold then release
    cyc(25 * TD);
    ring_cmp = 1'b0;
    cyc(3 * TD);
    check("R4 ceiling, still qualified", ring_n, 1'b0);
    cyc(TD + 16);
    check("R5 disqualified below level", ring_n, 1'b1);

    // R4 floor: long low hold then rise again
    cyc(20 * TD);
    ring_cmp = 1'b1;
    cyc((QL - 1) * TD);
    check("R4 floor, not yet qualified", ring_n, 1'b1);
    cyc(TD + 16);
    check("R4 floor, requalified", ring_n, 1'b0);

    // R9 sleep timer
    ring_cmp = 1'b0;
    line_act_n = 1'b1;
    wait_ring_off();
    cyc((SL - 2) * TD);
    check("R9 still awake before timeout", full_pwr, 1'b1);
    cyc(4 * TD);
    check("R9 asleep after timeout", full_pwr, 1'b0);
    check("R9 wake dropped after timeout", wake_req, 1'b0);

    // R10 carrier restarts timer
    line_act_n = 1'b0;
    ring_cmp = 1'b1;
    cyc((QL + 3) * TD);
    check("R8 requalified for R10 test", ring_n, 1'b0);
    ring_cmp = 1'b0;
    line_act_n = 1'b1;
    wait_ring_off();
    cyc(10 * TD);
    carrier_ok = 1'b1;
    cyc(3);
    carrier_ok = 1'b0;
    cyc((SL - 2) * TD);
    check("R10 timer restarted by carrier", full_pwr, 1'b1);
    cyc(4 * TD);
    check("R10 asleep after restarted countdown", full_pwr, 1'b0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule